// File: doc/BRIEF.md
# Glitch-Free Three-Source Clock Mode Switch

This block selects the operating clock of a subsystem from three raw sources. The first is a high-speed oscillator, used after a divide by two. The second is a PLL output, used as it arrives. The third is a low-speed oscillator, used after a divide by two or by four. Software writes one 6-bit control word on the main-clock write port. The block then moves from the mode in effect to the requested mode and never truncates a clock phase on the way. Before it hands over to the PLL, it waits a fixed stabilization interval counted in main-clock cycles. When it leaves the PLL, it waits for a rising edge of the halved main clock to fall inside a single PLL cycle, and gives up waiting after a bounded number of PLL cycles. When it enters the low-speed mode, the changeover is synchronized to the divided low-speed clock.

Each source has its own gate. The gate resynchronizes its request through two flip-flops clocked by that source and opens or closes only while the source is low. A sequencer in the main-clock domain closes the old gate, sees that it has closed, and only then opens the new gate. There is no path between the PLL and the low-speed source in either direction: the sequencer always passes through main clock mode. The multiplier field is forwarded unchanged to the external PLL.

Top module: `cms_clk_switch`

## Requirements
- R1: After reset, mode_o is 2'b00 (main), busy_o is 0 and pll_mult_o is 0. clk_o runs at the main oscillator frequency divided by 2. The low-speed divide select resets to divide-by-4.
- R2: A write with wr_en_i high stores wr_data_i in the control word. Bit 5 is main select (1 = main, 0 = PLL). Bit 4 is low-speed select (0 = low-speed mode requested). Bits 3:1 are the PLL multiplier, which appears on pll_mult_o one main cycle after the write. Bit 0 is the low-speed divide (1 = divide by 4, 0 = divide by 2).
- R3: Clearing main select in main mode keeps mode_o at 2'b00 for at least 2^STAB_LOG2 main cycles. After that, mode_o becomes 2'b01 and clk_o follows the PLL clock.
- R4: Setting main select in PLL mode returns mode_o to 2'b00 within 40 main cycles, and clk_o again runs at main/2.
- R5: Clearing low-speed select in main mode makes mode_o 2'b10, and clk_o runs at the low-speed clock divided by 4 or by 2, as bit 0 selects.
- R6: Low-speed select takes priority over main select. Clearing it while in PLL mode gives mode_o 2'b00 first and then 2'b10.
- R7: busy_o is high from the main cycle after a write that asks for a different mode until mode_o shows the requested mode.
- R8: A write made during a transition is stored at once but does not alter that transition. Once the transition completes, the stored request is acted on.
- R9: At most one source gate is open at any time. No high or low phase of clk_o is shorter than the shortest half-period of the sources.
- R10: Once the PLL gate's request is removed, the gate closes at the first PLL cycle that holds a rising edge of the halved main clock. If no such cycle comes, it closes after at most 12 PLL cycles.
- R11: Setting low-speed select again while in low-speed mode returns mode_o to 2'b00 with clk_o at main/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main_i | input | 1 | Raw high-speed oscillator clock; also clocks the control logic |
| clk_sub_i | input | 1 | Raw low-speed oscillator clock |
| clk_pll_i | input | 1 | PLL output clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe (main clock domain) |
| wr_data_i | input | 6 | Control word: [5] main select, [4] low-speed select, [3:1] multiplier, [0] divide |
| clk_o | output | 1 | Selected operating clock |
| mode_o | output | 2 | Mode in effect: 00 main, 01 PLL, 10 low-speed |
| busy_o | output | 1 | Mode change pending or in progress |
| pll_mult_o | output | 3 | Multiplier select for the external PLL |

## Verification
The register is written on a falling main edge, so pll_mult_o and busy_o are sampled at the next falling edge, one register stage later. The PLL entry is checked twice. Just before 2^14 main cycles have passed since the write, mode_o must still read main. Within a few hundred further cycles it must read PLL. Exits and low-speed entries involve synchronizers in several domains, so each is polled on every falling main edge against a stated cycle bound. The output clock period is measured only after two edges of clk_o have been skipped. A monitor records every clk_o phase width and every main-mode visit for the ordering checks.

// File: rtl/cms_pkg.sv
`timescale 1ns/1ps
package cms_pkg;

  typedef enum logic [1:0] {
    MD_MAIN = 2'd0,
    MD_PLL  = 2'd1,
    MD_SUB  = 2'd2
  } md_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_STAB,
    SQ_DROP,
    SQ_RAISE
  } sq_e;

  typedef struct packed {
    logic       main_sel;  // 1: main, 0: PLL
    logic       sub_sel;   // 0: low-speed requested
    logic [2:0] mult;
    logic       sub_div4;  // 1: divide by 4
  } cfg_t;

  localparam cfg_t CFG_RST = '{main_sel: 1'b1, sub_sel: 1'b1, mult: 3'd0, sub_div4: 1'b1};

  // Mode requested by the control word; low-speed select wins.
  function automatic md_e wanted_mode(input cfg_t c);
    if (!c.sub_sel)       return MD_SUB;
    else if (!c.main_sel) return MD_PLL;
    else                  return MD_MAIN;
  endfunction

  // Next hop: any move away from PLL or low-speed goes through main.
  function automatic md_e hop_target(input md_e cur, input md_e want);
    if (cur != MD_MAIN && want != cur) return MD_MAIN;
    return want;
  endfunction

endpackage

// File: rtl/cms_div.sv
`timescale 1ns/1ps
module cms_div #(
  parameter int STAGES = 2,
  localparam int TW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] tap_i,
  output logic          clk_o
);
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign clk_o = cnt_q[tap_i];
endmodule

// File: rtl/cms_gate.sv
`timescale 1ns/1ps
module cms_gate #(
  parameter bit RST_ON   = 1'b0,
  parameter bit USE_COIN = 1'b0,
  parameter int COIN_MAX = 12,
  localparam int CW = $clog2(COIN_MAX + 1)
) (
  input  logic clk_src_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ref_i,
  output logic en_o,
  output logic clk_o
);
  logic req_s1, req_s2, en_q, release_w;

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s1 <= RST_ON;
      req_s2 <= RST_ON;
    end else begin
      req_s1 <= req_i;
      req_s2 <= req_s1;
    end
  end

  generate
    if (USE_COIN) begin : g_coin
      localparam logic [CW-1:0] LIM = CW'(COIN_MAX - 1);
      logic          ref_q1, ref_q2, coin_w;
      logic [CW-1:0] wait_q;

      always_ff @(posedge clk_src_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ref_q1 <= 1'b0;
          ref_q2 <= 1'b0;
          wait_q <= '0;
        end else begin
          ref_q1 <= ref_i;
          ref_q2 <= ref_q1;
          if (req_s2 || !en_q)  wait_q <= '0;
          else if (wait_q != LIM) wait_q <= wait_q + 1'b1;
        end
      end

      // reference clock rose within the last source cycle
      assign coin_w    = ref_q1 & ~ref_q2;
      assign release_w = coin_w | (wait_q == LIM);

      // R10
      coin_window_chk: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
        (wait_q == LIM && !req_s2) |=> !en_q);
    end else begin : g_plain
      logic unused_ref;
      assign unused_ref = ref_i;
      assign release_w  = 1'b1;
    end
  endgenerate

  // enable changes only while the source is low
  always_ff @(negedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= RST_ON;
    else if (req_s2)    en_q <= 1'b1;
    else if (release_w) en_q <= 1'b0;
  end

  assign en_o  = en_q;
  assign clk_o = clk_src_i & en_q;
endmodule

// File: rtl/cms_seq.sv
`timescale 1ns/1ps
module cms_seq
  import cms_pkg::*;
#(
  parameter int STAB_LOG2 = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cfg_t       cfg_i,
  input  logic [2:0] ack_i,
  output logic [2:0] req_o,
  output md_e        mode_o,
  output logic       busy_o
);
  sq_e                  state_q;
  md_e                  cur_q, tgt_q, want_w, hop_w;
  logic [2:0]           req_q, ack_s1, ack_s2;
  logic [STAB_LOG2-1:0] stab_q;
  logic                 stab_done_w;

  assign want_w      = wanted_mode(cfg_i);
  assign hop_w       = hop_target(cur_q, want_w);
  assign stab_done_w = &stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_s1 <= 3'b001;
      ack_s2 <= 3'b001;
    end else begin
      ack_s1 <= ack_i;
      ack_s2 <= ack_s1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cur_q   <= MD_MAIN;
      tgt_q   <= MD_MAIN;
      req_q   <= 3'b001;
      stab_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (hop_w != cur_q) begin
          tgt_q   <= hop_w;
          stab_q  <= '0;
          state_q <= (hop_w == MD_PLL) ? SQ_STAB : SQ_DROP;
        end
        SQ_STAB: begin
          if (stab_done_w) state_q <= SQ_DROP;
          else             stab_q  <= stab_q + 1'b1;
        end
        SQ_DROP: begin
          req_q[cur_q] <= 1'b0;
          if (!req_q[cur_q] && !ack_s2[cur_q]) state_q <= SQ_RAISE;
        end
        SQ_RAISE: begin
          req_q[tgt_q] <= 1'b1;
          if (req_q[tgt_q] && ack_s2[tgt_q]) begin
            cur_q   <= tgt_q;
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign mode_o = cur_q;
  assign busy_o = (state_q != SQ_IDLE) || (want_w != cur_q);

  // R3
  stab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_STAB) |-> (cur_q == MD_MAIN && req_q == 3'b001));

  // R8
  tgt_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SQ_IDLE) |=> $stable(tgt_q));

  // R9
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_q));

  // R9
  mode_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> (ack_s2 == (3'b001 << cur_q)));
endmodule

// File: rtl/cms_clk_switch.sv
`timescale 1ns/1ps
module cms_clk_switch
  import cms_pkg::*;
#(
  parameter int STAB_LOG2 = 14,
  parameter int COIN_MAX  = 12
) (
  input  logic       clk_main_i,
  input  logic       clk_sub_i,
  input  logic       clk_pll_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [5:0] wr_data_i,
  output logic       clk_o,
  output logic [1:0] mode_o,
  output logic       busy_o,
  output logic [2:0] pll_mult_o
);
  localparam int NSRC = 3;

  cfg_t            cfg_q;
  md_e             mode_w;
  logic            main_half, sub_slow;
  logic [NSRC-1:0] src_clk, gate_clk, gate_en, req_w;

  always_ff @(posedge clk_main_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= CFG_RST;
    else if (wr_en_i) cfg_q <= cfg_t'(wr_data_i);
  end

  cms_div #(.STAGES(1)) u_main_div (
    .clk_i(clk_main_i), .rst_ni(rst_ni), .tap_i(1'b0), .clk_o(main_half)
  );

  cms_div #(.STAGES(2)) u_sub_div (
    .clk_i(clk_sub_i), .rst_ni(rst_ni), .tap_i(cfg_q.sub_div4), .clk_o(sub_slow)
  );

  // index follows md_e: 0 main, 1 PLL, 2 low-speed
  assign src_clk = {sub_slow, clk_pll_i, main_half};

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      cms_gate #(
        .RST_ON  (g == 0),
        .USE_COIN(g == 1),
        .COIN_MAX(COIN_MAX)
      ) u_gate (
        .clk_src_i(src_clk[g]),
        .rst_ni   (rst_ni),
        .req_i    (req_w[g]),
        .ref_i    (main_half),
        .en_o     (gate_en[g]),
        .clk_o    (gate_clk[g])
      );
    end
  endgenerate

  cms_seq #(.STAB_LOG2(STAB_LOG2)) u_seq (
    .clk_i (clk_main_i),
    .rst_ni(rst_ni),
    .cfg_i (cfg_q),
    .ack_i (gate_en),
    .req_o (req_w),
    .mode_o(mode_w),
    .busy_o(busy_o)
  );

  assign clk_o      = |gate_clk;
  assign mode_o     = mode_w;
  assign pll_mult_o = cfg_q.mult;

  // R9
  src_excl_chk: assert property (@(posedge clk_main_i) disable iff (!rst_ni)
    $onehot0(gate_en));
endmodule

// File: tb/test_cms_clk_switch.sv
`timescale 1ns/1ps
module test_cms_clk_switch;
  localparam int  CLK_PERIOD = 10;
  localparam real PLL_HALF   = 3.0;
  localparam real SUB_HALF   = 38.0;
  localparam int  STAB       = 1 << 14;
  localparam int  WD_CYCLES  = 150000;

  logic clk_main = 1'b0, clk_sub = 1'b0, clk_pll = 1'b0;
  logic rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic clk_o, busy;
  logic [1:0] mode;
  logic [2:0] mult;

  int checks = 0, fails = 0, short_cnt = 0;
  bit saw_main = 1'b0;
  realtime last_r = 0, last_f = 0;
  bit have_r = 1'b0, have_f = 1'b0;

  always #(CLK_PERIOD / 2) clk_main = ~clk_main;
  initial begin #1; forever #(PLL_HALF) clk_pll = ~clk_pll; end
  always #(SUB_HALF) clk_sub = ~clk_sub;

  cms_clk_switch i_cms_clk_switch (
    .clk_main_i(clk_main), .clk_sub_i(clk_sub), .clk_pll_i(clk_pll),
    .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .clk_o(clk_o), .mode_o(mode), .busy_o(busy), .pll_mult_o(mult)
  );

  // phase-width monitor (R9)
  always @(posedge clk_o) begin
    if (rst_n && have_f && ($realtime - last_f) < PLL_HALF - 0.1) short_cnt++;
    last_r = $realtime; have_r = 1'b1;
  end
  always @(negedge clk_o) begin
    if (rst_n && have_r && ($realtime - last_r) < PLL_HALF - 0.1) short_cnt++;
    last_f = $realtime; have_f = 1'b1;
  end
  always @(mode) if (mode == 2'b00) saw_main = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] word(input bit msel, input bit ssel,
                                      input logic [2:0] m, input bit d4);
    return {msel, ssel, m, d4};
  endfunction

  task automatic wr(input logic [5:0] d);
    @(negedge clk_main); wr_en = 1'b1; wr_data = d;
    @(negedge clk_main); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_main);
  endtask

  task automatic wait_mode(input logic [1:0] exp, input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk_main);
      if (mode == exp) begin ok = 1'b1; break; end
    end
  endtask

  task automatic period_ps(output longint p);
    realtime t0;
    @(posedge clk_o); @(posedge clk_o);
    t0 = $realtime;
    @(posedge clk_o);
    p = longint'(($realtime - t0) * 1000.0);
  endtask

  task automatic t_reset;
    longint p;
    chk(mode == 2'b00, "R1", "mode", mode, 0);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(mult == 3'd0, "R1", "mult", mult, 0);
    period_ps(p);
    chk(p == 2 * CLK_PERIOD * 1000, "R1", "main/2 period ps", p, 2 * CLK_PERIOD * 1000);
  endtask

  task automatic t_pll_entry;
    bit ok; longint p;
    wr(word(1'b0, 1'b1, 3'b101, 1'b1));
    chk(mult == 3'b101, "R2", "multiplier field", mult, 5);
    chk(busy == 1'b1, "R7", "busy after write", busy, 1);
    idle(STAB - 10);
    chk(mode == 2'b00, "R3", "mode before wait ends", mode, 0);
    wait_mode(2'b01, 400, ok);
    chk(ok, "R3", "mode reaches PLL", mode, 1);
    idle(2);
    chk(busy == 1'b0, "R7", "busy after PLL entry", busy, 0);
    period_ps(p);
    chk(p == 6000, "R3", "PLL period ps", p, 6000);
  endtask

  task automatic t_pll_exit;
    bit ok; longint p;
    wr(word(1'b1, 1'b1, 3'b101, 1'b1));
    wait_mode(2'b00, 40, ok);
    chk(ok, "R4", "back to main within bound", mode, 0);
    period_ps(p);
    chk(p == 2 * CLK_PERIOD * 1000, "R4", "main period ps", p, 2 * CLK_PERIOD * 1000);
    chk(busy == 1'b0, "R7", "busy after exit", busy, 0);
  endtask

  task automatic t_sub(input bit d4);
    bit ok; longint p, e;
    e = longint'(SUB_HALF * 2.0 * (d4 ? 4.0 : 2.0) * 1000.0);
    wr(word(1'b1, 1'b0, 3'b101, d4));
    wait_mode(2'b10, 400, ok);
    chk(ok, "R5", "mode reaches low-speed", mode, 2);
    period_ps(p);
    chk(p == e, "R5", "low-speed period ps", p, e);
    wr(word(1'b1, 1'b1, 3'b101, d4));
    wait_mode(2'b00, 400, ok);
    chk(ok, "R11", "low-speed exit to main", mode, 0);
    period_ps(p);
    chk(p == 2 * CLK_PERIOD * 1000, "R11", "main period ps", p, 2 * CLK_PERIOD * 1000);
  endtask

  task automatic t_two_step;
    bit ok; longint p;
    wr(word(1'b0, 1'b1, 3'b010, 1'b1));
    wait_mode(2'b01, STAB + 400, ok);
    chk(ok, "R6", "setup reaches PLL", mode, 1);
    idle(4);
    saw_main = 1'b0;
    wr(word(1'b0, 1'b0, 3'b010, 1'b1));
    wait_mode(2'b10, 800, ok);
    chk(ok, "R6", "ends in low-speed", mode, 2);
    chk(saw_main, "R6", "passed through main", saw_main, 1);
    period_ps(p);
    chk(p == 304000, "R6", "low-speed period ps", p, 304000);
    wr(word(1'b1, 1'b1, 3'b010, 1'b1));
    wait_mode(2'b00, 400, ok);
    chk(ok, "R11", "return to main", mode, 0);
  endtask

  task automatic t_deferred;
    bit ok;
    wr(word(1'b0, 1'b1, 3'b001, 1'b1));
    idle(100);
    wr(word(1'b1, 1'b1, 3'b011, 1'b1));
    chk(mult == 3'b011, "R8", "write stored while busy", mult, 3);
    chk(busy == 1'b1, "R8", "still busy", busy, 1);
    idle(STAB - 200);
    chk(mode == 2'b00, "R8", "mode during wait", mode, 0);
    wait_mode(2'b01, 400, ok);
    chk(ok, "R8", "transition completes to PLL", mode, 1);
    wait_mode(2'b00, 60, ok);
    chk(ok, "R8", "deferred request applied", mode, 0);
    idle(2);
    chk(busy == 1'b0, "R7", "busy cleared", busy, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(WD_CYCLES * CLK_PERIOD);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_pll_entry();
    t_pll_exit();
    t_sub(1'b1);
    t_sub(1'b0);
    t_two_step();
    t_deferred();
    chk(short_cnt == 0, "R9", "short clk_o phases", short_cnt, 0);
    summary();
    $finish;
  end
endmodule